// File: doc/BRIEF.md
# Per-Channel Hit Time Merger and Queue

This block sits behind a channel selector and serves a single detector channel. It receives a stream of 32-bit words in which the upper four bits name the kind of word. It keeps the latest coarse timestamp. Each hit word carries a fine time, and the block joins that fine time to the stored timestamp to produce a 40-bit absolute time. The result is placed in a small first-in first-out queue, which a downstream event builder drains. Words that cannot contribute to event building are discarded before they reach the queue.

The coarse timestamp is 28 bits wide and has an LSB of roughly 400 ns. The fine time is 19 bits wide and has an LSB of roughly 100 ps. The two fields share seven bits of the same time span: coarse bits 6:0 match fine bits 18:12. A new timestamp normally arrives four times per fine-time wrap period. The fine counter can therefore wrap after the stored timestamp was taken. The block detects this case from the shared bits and carries one into the coarse part.

Top module: `chbuf_channel`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `empty` is 1, `ready` is 1 and `overflow` is 0.
- R2: Hit words that arrive before the first timestamp word after reset are dropped and create no queue entry.
- R3: A word with kind code 4'hA (bits 31:28) is a timestamp. Its bits 27:0 replace the stored coarse time, and it creates no queue entry.
- R4: A word with kind code 4'h4 (leading edge) or 4'h5 (trailing edge) is a hit, and its fine time is bits 18:0. Bits 27:19 are ignored. The queued time is {T[27:7], F[18:0]}, and `out_trailing` is 1 only for code 4'h5.
- R5: When F[18:17] is 2'b00 and T[6:5] is 2'b11, the upper 21 bits of the queued time are T[27:7]+1, taken modulo 2^21.
- R6: Words with kind code 4'hB (trailer), and every code other than 4'h4, 4'h5 and 4'hA, are dropped.
- R7: Entries leave the queue in arrival order. Up to 16 entries are held. `ready` is 1 whenever fewer than 16 entries are held.
- R8: A hit that reaches a full queue with no pop in the same cycle is discarded. This sets `overflow`, which stays set until reset, and leaves the stored entries unchanged.
- R9: If a hit reaches a full queue in the same cycle as a pop, both take effect. The queue stays at 16 entries and `overflow` does not change.
- R10: A pop while `empty` is 1 has no effect.
- R11: When `in_valid` is 0, the word on `in_word` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_word` carries a word this cycle |
| in_word | input | 32 | Input word: kind code in bits 31:28 |
| pop | input | 1 | Remove the head entry |
| out_time | output | 40 | Absolute time of the head entry |
| out_trailing | output | 1 | Head entry is a trailing edge |
| empty | output | 1 | Queue holds no entry |
| ready | output | 1 | Queue can accept an entry |
| overflow | output | 1 | Sticky: a hit was lost to a full queue |

## Verification
A merged hit can be written to the queue in the same cycle that the consumer pops the head. When the queue is full, the outcome depends on both. The bench fills the queue to 16 entries with popping disabled. It then sends one hit and enables a single pop timed to fall on the cycle the hit is written. It expects `overflow` to stay low and `ready` to stay low, and the drained order must show that the popped head left and the new hit arrived at the tail. A second hit sent with no pop must then set `overflow` and leave the drained contents unchanged.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;

    localparam int WORD_W    = 32;
    localparam int KIND_W    = 4;
    localparam int COARSE_W  = 28;
    localparam int FINE_W    = 19;
    localparam int OVERLAP_W = 7;
    localparam int UPPER_W   = COARSE_W - OVERLAP_W;
    localparam int TIME_W    = UPPER_W + FINE_W;

    localparam logic [KIND_W-1:0] KIND_LEAD    = 4'h4;
    localparam logic [KIND_W-1:0] KIND_TRAIL   = 4'h5;
    localparam logic [KIND_W-1:0] KIND_COARSE  = 4'hA;
    localparam logic [KIND_W-1:0] KIND_TRAILER = 4'hB;

    typedef enum logic [1:0] {
        CLS_DROP   = 2'd0,
        CLS_COARSE = 2'd1,
        CLS_HIT    = 2'd2
    } word_class_e;

    typedef struct packed {
        logic              trailing;
        logic [TIME_W-1:0] abs_time;
    } entry_t;

    function automatic word_class_e classify(input logic [KIND_W-1:0] kind);
        word_class_e c;
        case (kind)
            KIND_COARSE:           c = CLS_COARSE;
            KIND_LEAD, KIND_TRAIL: c = CLS_HIT;
            default:               c = CLS_DROP;
        endcase
        return c;
    endfunction

    // Shared bits: coarse[6:5] late in its window while fine[18:17] already wrapped.
    function automatic logic [TIME_W-1:0] join_time(input logic [COARSE_W-1:0] coarse,
                                                    input logic [FINE_W-1:0]   fine);
        logic [UPPER_W-1:0] upper;
        logic               wrapped;
        wrapped = (fine[FINE_W-1 -: 2] == 2'b00) && (coarse[OVERLAP_W-1 -: 2] == 2'b11);
        upper   = coarse[COARSE_W-1:OVERLAP_W] + UPPER_W'(wrapped);
        return {upper, fine};
    endfunction

endpackage

// File: rtl/chbuf_stamp_merge.sv
module chbuf_stamp_merge
    import chbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              hit_vld,
    output entry_t            hit_entry
);

    logic [COARSE_W-1:0] coarse_q;
    logic                seen_q;
    logic                hit_vld_q;
    entry_t              hit_q;
    word_class_e         cls;
    entry_t              fresh;

    assign cls            = classify(in_word[WORD_W-1 -: KIND_W]);
    assign fresh.trailing = (in_word[WORD_W-1 -: KIND_W] == KIND_TRAIL);
    assign fresh.abs_time = join_time(coarse_q, in_word[FINE_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q  <= '0;
            seen_q    <= 1'b0;
            hit_vld_q <= 1'b0;
            hit_q     <= '0;
        end else begin
            hit_vld_q <= 1'b0;
            if (in_valid) begin
                case (cls)
                    CLS_COARSE: begin
                        coarse_q <= in_word[COARSE_W-1:0];
                        seen_q   <= 1'b1;
                    end
                    CLS_HIT: begin
                        if (seen_q) begin
                            hit_vld_q <= 1'b1;
                            hit_q     <= fresh;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign hit_vld   = hit_vld_q;
    assign hit_entry = hit_q;

    // R2: nothing leaves this stage until a timestamp has been taken
    a_r2_no_hit_before_stamp: assert property (@(posedge clk) disable iff (rst)
        !seen_q |=> !hit_vld_q);

    // R3: a timestamp word lands in the coarse register
    a_r3_stamp_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[WORD_W-1 -: KIND_W] == KIND_COARSE)
            |=> (coarse_q == $past(in_word[COARSE_W-1:0])) && !hit_vld_q);

    // R6: trailer words never produce a hit
    a_r6_trailer_dropped: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[WORD_W-1 -: KIND_W] == KIND_TRAILER) |=> !hit_vld_q);

    // R11: an idle input cycle produces nothing
    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !hit_vld_q);

endmodule

// File: rtl/chbuf_fifo.sv
module chbuf_fifo
    import chbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  entry_t wr_data,
    input  logic   rd_en,
    output entry_t rd_data,
    output logic   empty,
    output logic   ready,
    output logic   overflow
);

    localparam int             AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]    FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0]  LAST_IDX = AW'(DEPTH - 1);

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [AW:0]     count_q;
    logic            overflow_q;
    logic            full;
    logic            do_rd, do_wr;

    assign full  = (count_q == FULL_CNT);
    assign do_rd = rd_en && (count_q != '0);
    assign do_wr = wr_en && (!full || do_rd);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            count_q    <= '0;
            overflow_q <= 1'b0;
        end else begin
            if (do_wr) wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
            if (do_rd) rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: ;
            endcase
            if (wr_en && !do_wr) overflow_q <= 1'b1;
        end
    end

    assign rd_data  = mem[rd_ptr_q];
    assign empty    = (count_q == '0);
    assign ready    = !full;
    assign overflow = overflow_q;

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_CNT);

    // R8: the loss flag is sticky
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_q |=> overflow_q);

    // R8: a write into a full queue without a pop is lost
    a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> (count_q == FULL_CNT) && overflow_q);

    // R9: write plus pop at full keeps the queue full and the flag unchanged
    a_r9_push_pop_full: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && full) |=> (count_q == FULL_CNT) && $stable(overflow_q));

    // R10: a pop on an empty queue changes nothing
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> empty);

endmodule

// File: rtl/chbuf_channel.sv
module chbuf_channel
    import chbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              pop,
    output logic [TIME_W-1:0] out_time,
    output logic              out_trailing,
    output logic              empty,
    output logic              ready,
    output logic              overflow
);

    logic   hit_vld;
    entry_t hit_entry;
    entry_t head;

    chbuf_stamp_merge i_merge (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .hit_vld   (hit_vld),
        .hit_entry (hit_entry)
    );

    chbuf_fifo #(.DEPTH(DEPTH)) i_queue (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (hit_vld),
        .wr_data  (hit_entry),
        .rd_en    (pop),
        .rd_data  (head),
        .empty    (empty),
        .ready    (ready),
        .overflow (overflow)
    );

    assign out_time     = head.abs_time;
    assign out_trailing = head.trailing;

    // R1: queue starts clean after reset
    a_r1_clean_start: assert property (@(posedge clk)
        $past(rst) |-> empty && ready && !overflow);

endmodule

// File: tb/test_chbuf_channel.sv
module test_chbuf_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        pop;
    logic [39:0] out_time;
    logic        out_trailing;
    logic        empty, ready, overflow;

    bit mon_pop = 1'b0;
    bit raw_pop = 1'b0;
    bit pop_en  = 1'b0;
    assign pop = mon_pop | raw_pop;

    int n_chk = 0;
    int n_err = 0;

    logic [40:0] exp_q[$];
    bit          model_seen = 1'b0;
    logic [27:0] model_ts = '0;

    always #4 clk = ~clk;

    chbuf_channel i_chbuf_channel (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .pop(pop),
        .out_time(out_time), .out_trailing(out_trailing),
        .empty(empty), .ready(ready), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [40:0] expect_of(input bit trl, input logic [27:0] ts, input logic [18:0] f);
        logic [20:0] up;
        up = ts[27:7];
        if (f[18:17] == 2'b00 && ts[6:5] == 2'b11) up = up + 21'd1;
        return {trl, up, f};
    endfunction

    // driver: one word, expected entry queued for the scoreboard
    task automatic put_word(input logic [3:0] kind, input logic [27:0] body, input bit keep);
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_word  = {kind, body};
        if (kind == 4'hA) begin
            model_ts   = body;
            model_seen = 1'b1;
        end else if ((kind == 4'h4 || kind == 4'h5) && model_seen && keep)
            exp_q.push_back(expect_of(kind == 4'h5, model_ts, body[18:0]));
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic hit(input bit trl, input logic [18:0] f, input bit keep);
        put_word(trl ? 4'h5 : 4'h4, {9'h1A5, f}, keep);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain(input string req);
        pop_en = 1'b1;
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(posedge clk);
        idle(3);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor: compare head with scoreboard when popping
    always @(negedge clk) begin
        mon_pop = 1'b0;
        if (!rst && pop_en && !empty) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R2 R6 R7 R11 unexpected entry", {out_trailing, out_time}, 0);
            else begin
                chk({out_trailing, out_time} == exp_q[0], "R4 R5 R7 head entry",
                    {out_trailing, out_time}, exp_q[0]);
                void'(exp_q.pop_front());
            end
            mon_pop = 1'b1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk);
        chk(empty && ready && !overflow, "R1 during reset", {empty, ready, overflow}, 3'b110);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        chk(empty && ready && !overflow, "R1 after reset", {empty, ready, overflow}, 3'b110);

        // R2: hits before any timestamp
        hit(1'b0, 19'h12345, 1'b0);
        hit(1'b1, 19'h00001, 1'b0);
        idle(3);
        chk(empty == 1'b1, "R2 early hits dropped", empty, 1);

        // R3: timestamp makes no entry
        put_word(4'hA, 28'h0123456, 1'b1);
        idle(3);
        chk(empty == 1'b1, "R3 timestamp not queued", empty, 1);

        // R4: plain merge, leading and trailing
        pop_en = 1'b1;
        hit(1'b0, 19'h7ABCD, 1'b1);
        hit(1'b1, 19'h00010, 1'b1);
        drain("R4 merged hits");

        // R5: rollover carry, including wrap of the upper field
        put_word(4'hA, 28'hFFFFFFF, 1'b1);
        hit(1'b0, 19'h01234, 1'b1);
        hit(1'b1, 19'h40000, 1'b1);
        put_word(4'hA, 28'h0000060, 1'b1);
        hit(1'b1, 19'h1FFFF, 1'b1);
        hit(1'b0, 19'h20000, 1'b1);
        drain("R5 rollover hits");

        // R6: trailer and unknown kinds
        put_word(4'hB, 28'h0000777, 1'b1);
        put_word(4'h7, 28'h0001234, 1'b1);
        put_word(4'h0, 28'h0000000, 1'b1);
        idle(3);
        chk(empty == 1'b1, "R6 trailer and unknown dropped", empty, 1);

        // R11: hit pattern on the bus without valid
        @(posedge clk); #2;
        in_word = {4'h4, 9'h0, 19'h00ABC};
        idle(4);
        in_word = '0;
        chk(empty == 1'b1, "R11 invalid word ignored", empty, 1);

        // R10: pops on an empty queue
        raw_pop = 1'b1;
        idle(4);
        raw_pop = 1'b0;
        chk(empty && ready, "R10 empty pop no change", {empty, ready}, 2'b11);
        hit(1'b0, 19'h05555, 1'b1);
        drain("R10 entry after empty pop");
        chk(empty == 1'b1, "R10 count intact", empty, 1);

        // R7: fill to depth
        pop_en = 1'b0;
        for (int i = 0; i < 15; i++) hit(i[0], 19'(32'h100 * i + 7), 1'b1);
        idle(3);
        chk(ready == 1'b1, "R7 ready with 15 entries", ready, 1);
        hit(1'b1, 19'h3FFFF, 1'b1);
        idle(3);
        chk(!ready && !empty && !overflow, "R7 full at 16", {ready, empty, overflow}, 3'b000);

        // R9: write and pop in the same cycle at full
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_word  = {4'h4, 9'h0, 19'h0BEEF};
        exp_q.push_back(expect_of(1'b0, model_ts, 19'h0BEEF));
        @(posedge clk); #2;
        in_valid = 1'b0;
        pop_en   = 1'b1;
        @(posedge clk); #2;
        pop_en   = 1'b0;
        @(negedge clk);
        chk(!ready && !empty && !overflow, "R9 push and pop at full", {ready, empty, overflow}, 3'b000);

        // R8: write into full queue without pop
        hit(1'b1, 19'h0DEAD, 1'b0);
        idle(3);
        chk(overflow && !ready, "R8 overflow on full push", {overflow, ready}, 2'b10);
        drain("R7 R8 R9 drained contents");
        chk(empty && ready, "R7 empty after drain", {empty, ready}, 2'b11);
        chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

        finish_run();
    end

endmodule